// File: doc/BRIEF.md
# Parity-Checked Two-Clock Word Memory

This block is a 256-word by 9-bit memory with a write port and a read port that each run on their own clock. Bit 8 of every word can carry a parity bit. The block checks that bit on the way in and on the way out. A run-time polarity input sets whether a good word has an odd or an even number of ones. Each port raises its own active-high error flag when a word with bad parity passes through it during an enabled access.

Each port is enabled by a pair of active-low inputs, a select and a strobe. Both must be low for an access to take place. Two parameters decide, each port on its own, whether that port is clocked or free-running.

A clocked write stores on the rising write clock. A free-running write stores the word when the enable pair goes inactive, so address and data must be held steady until then. A clocked read registers the word and its error flag on the rising read clock. A free-running read shows the addressed word combinationally while it is enabled. In every mode the read output keeps its last shown value while the read port is idle.

Top module: `parity_dpram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (256 by 9 by default). A word written at a write address is returned by a later read at the same read address, including addresses 0 and 255.
- R2: A write takes place only when wr_sel_n and wr_stb_n are both low. With either one high, the stored contents are unchanged.
- R3: A read takes place only when rd_sel_n and rd_stb_n are both low. Otherwise rd_data keeps its last value and rd_par_err is low.
- R4: A word has good parity when the XOR of all DATA_W bits, parity bit included, equals par_odd_sel. So par_odd_sel=1 means an odd count of ones and par_odd_sel=0 means an even count.
- R5: wr_par_err is high only for an enabled write whose incoming word has bad parity, and is low at all other times. On a clocked write port it is registered and is valid in the cycle after the write edge.
- R6: rd_par_err is high for an enabled read of a stored word with bad parity. On a clocked read port it is registered together with rd_data.
- R7: Parity is judged with the value of par_odd_sel at the time of the access. A stored word can therefore pass under one polarity and fail under the other.
- R8: With both ports clocked from the same clock, a read and a write to the same address in one cycle return the word held before that write.
- R9: With WR_SYNC=0, a write stores the word when the enable pair goes inactive and raises wr_par_err combinationally while enabled. With RD_SYNC=0, rd_data and rd_par_err follow rd_addr combinationally while the read is enabled.
- R10: While rst_n is low, rd_data, rd_par_err and wr_par_err are zero. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock (used when WR_SYNC=1) |
| rd_clk | input | 1 | Read-side clock (used when RD_SYNC=1) |
| rst_n | input | 1 | Active-low asynchronous reset of output registers and flags |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write word, top bit may be parity |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_stb_n | input | 1 | Write strobe, active low |
| rd_addr | input | ADDR_W | Read address |
| rd_sel_n | input | 1 | Read port select, active low |
| rd_stb_n | input | 1 | Read strobe, active low |
| par_odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_data | output | DATA_W | Read word |
| rd_par_err | output | 1 | Read parity error, active high |
| wr_par_err | output | 1 | Write parity error, active high |

## Verification
The bench builds two instances with the default 8-bit address and 9-bit word. The first has both ports clocked from one shared clock. This brings the same-address collision, the one-cycle registered flags and the gating of each half of the enable pair within reach. The second has both ports free-running. Its accesses are driven with plain time steps, which exposes the write that lands on the release of the enables, the combinational read and flags, and the hold of the output after the read is released.

// File: rtl/parity_dpram_pkg.sv
package parity_dpram_pkg;
   localparam int DEF_ADDR_W = 8;
   localparam int DEF_DATA_W = 9;

   typedef enum logic {
      PORT_FREE  = 1'b0,
      PORT_CLKED = 1'b1
   } port_timing_e;
endpackage

// File: rtl/parity_dpram_par.sv
module parity_dpram_par #(
   parameter int W = 9
) (
   input  logic [W-1:0] word,
   input  logic         odd_sel,
   output logic         bad
);
   // Good when the reduction XOR matches the chosen polarity.
   logic [W-1:0] chain;
   assign chain[0] = word[0];
   for (genvar i = 1; i < W; i++) begin : g_chain
      assign chain[i] = chain[i-1] ^ word[i];
   end
   assign bad = chain[W-1] ^ odd_sel;
endmodule

// File: rtl/parity_dpram_store.sv
module parity_dpram_store
   import parity_dpram_pkg::*;
#(
   parameter int           ADDR_W  = DEF_ADDR_W,
   parameter int           DATA_W  = DEF_DATA_W,
   parameter port_timing_e WR_MODE = PORT_CLKED
) (
   input  logic              wr_clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_act,
   input  logic              odd_sel,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word,
   output logic              wr_err
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              in_bad;

   parity_dpram_par #(.W(DATA_W)) u_in_par (
      .word    (wr_data),
      .odd_sel (odd_sel),
      .bad     (in_bad)
   );

   assign rd_word = mem[rd_addr];

   if (WR_MODE == PORT_CLKED) begin : g_wr_clked
      always_ff @(posedge wr_clk) begin
         if (wr_act) mem[wr_addr] <= wr_data;
      end
      always_ff @(posedge wr_clk or negedge rst_n) begin
         if (!rst_n) wr_err <= 1'b0;
         else        wr_err <= wr_act & in_bad;
      end
   end else begin : g_wr_free
      // Word lands as the enable pair is released.
      always_ff @(negedge wr_act) begin
         mem[wr_addr] <= wr_data;
      end
      assign wr_err = rst_n & wr_act & in_bad;
   end
endmodule

// File: rtl/parity_dpram_rdport.sv
module parity_dpram_rdport
   import parity_dpram_pkg::*;
#(
   parameter int           DATA_W  = DEF_DATA_W,
   parameter port_timing_e RD_MODE = PORT_CLKED
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              rd_act,
   input  logic              odd_sel,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err
);
   logic word_bad;

   parity_dpram_par #(.W(DATA_W)) u_out_par (
      .word    (rd_word),
      .odd_sel (odd_sel),
      .bad     (word_bad)
   );

   if (RD_MODE == PORT_CLKED) begin : g_rd_clked
      always_ff @(posedge rd_clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
         end else if (rd_act) begin
            rd_data <= rd_word;
            rd_err  <= word_bad;
         end else begin
            rd_err  <= 1'b0;
         end
      end
   end else begin : g_rd_free
      logic [DATA_W-1:0] held;
      // Keep the last shown word once the read is released.
      always_ff @(negedge rd_act or negedge rst_n) begin
         if (!rst_n) held <= '0;
         else        held <= rd_word;
      end
      assign rd_data = (rd_act && rst_n) ? rd_word : held;
      assign rd_err  = rst_n & rd_act & word_bad;
   end
endmodule

// File: rtl/parity_dpram.sv
module parity_dpram
   import parity_dpram_pkg::*;
#(
   parameter int ADDR_W  = DEF_ADDR_W,
   parameter int DATA_W  = DEF_DATA_W,
   parameter bit WR_SYNC = 1'b1,
   parameter bit RD_SYNC = 1'b1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_sel_n,
   input  logic              wr_stb_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_sel_n,
   input  logic              rd_stb_n,
   input  logic              par_odd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_par_err,
   output logic              wr_par_err
);
   localparam port_timing_e WR_MODE = WR_SYNC ? PORT_CLKED : PORT_FREE;
   localparam port_timing_e RD_MODE = RD_SYNC ? PORT_CLKED : PORT_FREE;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("parity_dpram: ADDR_W must lie in 1..12");
   end
   if (DATA_W < 2) begin : g_bad_data_w
      $error("parity_dpram: DATA_W must be at least 2");
   end

   logic              wr_act;
   logic              rd_act;
   logic [DATA_W-1:0] rd_word;

   assign wr_act = ~wr_sel_n & ~wr_stb_n;
   assign rd_act = ~rd_sel_n & ~rd_stb_n;

   parity_dpram_store #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .WR_MODE (WR_MODE)
   ) u_store (
      .wr_clk  (wr_clk),
      .rst_n   (rst_n),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_act  (wr_act),
      .odd_sel (par_odd_sel),
      .rd_addr (rd_addr),
      .rd_word (rd_word),
      .wr_err  (wr_par_err)
   );

   parity_dpram_rdport #(
      .DATA_W  (DATA_W),
      .RD_MODE (RD_MODE)
   ) u_rdport (
      .rd_clk  (rd_clk),
      .rst_n   (rst_n),
      .rd_act  (rd_act),
      .odd_sel (par_odd_sel),
      .rd_word (rd_word),
      .rd_data (rd_data),
      .rd_err  (rd_par_err)
   );
endmodule

// File: rtl/parity_dpram_chk.sv
module parity_dpram_chk #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 9,
   parameter bit WR_SYNC = 1'b1,
   parameter bit RD_SYNC = 1'b1
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_sel_n,
   input logic              wr_stb_n,
   input logic              rd_sel_n,
   input logic              rd_stb_n,
   input logic              par_odd_sel,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_par_err,
   input logic              wr_par_err
);
   logic w_en, r_en, w_in_bad;
   assign w_en     = !wr_sel_n && !wr_stb_n;
   assign r_en     = !rd_sel_n && !rd_stb_n;
   assign w_in_bad = ((^wr_data) != par_odd_sel);

   if (WR_SYNC) begin : g_wchk_s
      assert_wr_err_set_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
         (w_en && w_in_bad) |=> wr_par_err);
      assert_wr_err_idle_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
         !w_en |=> !wr_par_err);
   end else begin : g_wchk_a
      assert_wr_err_idle_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
         !w_en |-> !wr_par_err);
   end

   if (RD_SYNC) begin : g_rchk_s
      assert_rd_hold_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
         !r_en |=> ($stable(rd_data) && !rd_par_err));
      assert_rd_err_match_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
         r_en |=> (rd_par_err == ((^rd_data) != $past(par_odd_sel))));
   end else begin : g_rchk_a
      assert_rd_err_idle_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
         !r_en |-> !rd_par_err);
      assert_rd_err_match_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
         r_en |-> (rd_par_err == ((^rd_data) != par_odd_sel)));
   end
endmodule

bind parity_dpram parity_dpram_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .WR_SYNC (WR_SYNC),
   .RD_SYNC (RD_SYNC)
) u_chk (
   .wr_clk      (wr_clk),
   .rd_clk      (rd_clk),
   .rst_n       (rst_n),
   .wr_data     (wr_data),
   .wr_sel_n    (wr_sel_n),
   .wr_stb_n    (wr_stb_n),
   .rd_sel_n    (rd_sel_n),
   .rd_stb_n    (rd_stb_n),
   .par_odd_sel (par_odd_sel),
   .rd_data     (rd_data),
   .rd_par_err  (rd_par_err),
   .wr_par_err  (wr_par_err)
);

// File: tb/parity_dpram_bench.sv
module parity_dpram_bench;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic p_odd = 1'b1;
   int   checks = 0;
   int   errors = 0;

   always #(CLK_P/2) clk = ~clk;

   // clocked instance signals
   logic [7:0] s_wa = '0, s_ra = '0;
   logic [8:0] s_wd = '0;
   logic s_wsel = 1'b1, s_wstb = 1'b1, s_rsel = 1'b1, s_rstb = 1'b1;
   logic [8:0] s_rd;
   logic s_rpe, s_wpe;

   // free-running instance signals
   logic [7:0] a_wa = '0, a_ra = '0;
   logic [8:0] a_wd = '0;
   logic a_wsel = 1'b1, a_wstb = 1'b1, a_rsel = 1'b1, a_rstb = 1'b1;
   logic [8:0] a_rd;
   logic a_rpe, a_wpe;

   parity_dpram #(.WR_SYNC(1'b1), .RD_SYNC(1'b1)) u_parity_dpram (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
      .wr_addr(s_wa), .wr_data(s_wd), .wr_sel_n(s_wsel), .wr_stb_n(s_wstb),
      .rd_addr(s_ra), .rd_sel_n(s_rsel), .rd_stb_n(s_rstb),
      .par_odd_sel(p_odd), .rd_data(s_rd), .rd_par_err(s_rpe), .wr_par_err(s_wpe)
   );

   parity_dpram #(.WR_SYNC(1'b0), .RD_SYNC(1'b0)) u_parity_dpram_free (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
      .wr_addr(a_wa), .wr_data(a_wd), .wr_sel_n(a_wsel), .wr_stb_n(a_wstb),
      .rd_addr(a_ra), .rd_sel_n(a_rsel), .rd_stb_n(a_rstb),
      .par_odd_sel(p_odd), .rd_data(a_rd), .rd_par_err(a_rpe), .wr_par_err(a_wpe)
   );

   function automatic logic bad_par(logic [8:0] w, logic odd);
      return ((^w) != odd);
   endfunction

   task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic s_write(logic [7:0] a, logic [8:0] d);
      @(negedge clk);
      s_wa = a; s_wd = d; s_wsel = 1'b0; s_wstb = 1'b0;
      @(negedge clk);
      s_wsel = 1'b1; s_wstb = 1'b1;
      chk("R5 clocked write flag", {8'd0, s_wpe}, {8'd0, bad_par(d, p_odd)});
   endtask

   task automatic s_read(string req, logic [7:0] a, logic [8:0] exp);
      @(negedge clk);
      s_ra = a; s_rsel = 1'b0; s_rstb = 1'b0;
      @(negedge clk);
      s_rsel = 1'b1; s_rstb = 1'b1;
      chk({req, " data"}, s_rd, exp);
      chk("R6 clocked read flag", {8'd0, s_rpe}, {8'd0, bad_par(exp, p_odd)});
   endtask

   task automatic t_reset();
      chk("R10 reset rd_data", s_rd, 9'h000);
      chk("R10 reset flags", {7'd0, s_rpe, s_wpe}, 9'h000);
      chk("R10 reset free rd_data", a_rd, 9'h000);
      chk("R10 reset free flags", {7'd0, a_rpe, a_wpe}, 9'h000);
   endtask

   task automatic t_basic();
      p_odd = 1'b1;
      s_write(8'd0,   9'h001);
      s_write(8'd255, 9'h1FF);
      s_write(8'h5A,  9'h1A5);
      s_read("R1 addr 0",   8'd0,   9'h001);
      s_read("R1 addr 255", 8'd255, 9'h1FF);
      s_read("R4 odd good", 8'h5A,  9'h1A5);
   endtask

   task automatic t_gating();
      s_write(8'd3, 9'h103);
      @(negedge clk);
      s_wa = 8'd3; s_wd = 9'h107; s_wsel = 1'b1; s_wstb = 1'b0;
      @(negedge clk);
      chk("R5 no flag with select high", {8'd0, s_wpe}, 9'h000);
      s_wd = 9'h10F; s_wsel = 1'b0; s_wstb = 1'b1;
      @(negedge clk);
      chk("R5 no flag with strobe high", {8'd0, s_wpe}, 9'h000);
      s_wsel = 1'b1;
      s_read("R2 blocked writes", 8'd3, 9'h103);
   endtask

   task automatic t_hold();
      s_read("R3 setup", 8'd3, 9'h103);
      @(negedge clk);
      s_ra = 8'd0; s_rsel = 1'b0; s_rstb = 1'b1;
      @(negedge clk);
      chk("R3 hold strobe high", s_rd, 9'h103);
      s_rsel = 1'b1; s_rstb = 1'b0;
      @(negedge clk);
      chk("R3 hold select high", s_rd, 9'h103);
      chk("R3 flag low idle", {8'd0, s_rpe}, 9'h000);
      s_rstb = 1'b1;
   endtask

   task automatic t_bad();
      p_odd = 1'b1;
      s_write(8'd10, 9'h003);
      @(negedge clk);
      chk("R5 flag drops after write", {8'd0, s_wpe}, 9'h000);
      s_read("R6 bad stored word", 8'd10, 9'h003);
   endtask

   task automatic t_polarity();
      p_odd = 1'b0;
      s_read("R7 even pass", 8'd10, 9'h003);
      s_read("R7 even fail", 8'd3,  9'h103);
      s_write(8'd11, 9'h003);
      s_write(8'd12, 9'h001);
      chk("R7 even write flag", {8'd0, s_wpe}, 9'h001);
   endtask

   task automatic t_collide();
      p_odd = 1'b0;
      s_write(8'd20, 9'h101);
      @(negedge clk);
      s_wa = 8'd20; s_wd = 9'h103; s_wsel = 1'b0; s_wstb = 1'b0;
      s_ra = 8'd20; s_rsel = 1'b0; s_rstb = 1'b0;
      @(negedge clk);
      s_wsel = 1'b1; s_wstb = 1'b1; s_rsel = 1'b1; s_rstb = 1'b1;
      chk("R8 same address old word", s_rd, 9'h101);
      s_read("R8 new word after", 8'd20, 9'h103);
   endtask

   task automatic t_free();
      p_odd = 1'b1;
      a_wa = 8'd7; a_wd = 9'h107; #1;
      a_wsel = 1'b0; a_wstb = 1'b0; #1;
      chk("R9 free write flag", {8'd0, a_wpe}, 9'h001);
      a_wsel = 1'b1; a_wstb = 1'b1; #1;
      chk("R5 free flag idle", {8'd0, a_wpe}, 9'h000);
      a_wa = 8'd8; a_wd = 9'h007; #1;
      a_wsel = 1'b0; a_wstb = 1'b0; #1;
      chk("R9 free good write flag", {8'd0, a_wpe}, 9'h000);
      a_wsel = 1'b1; a_wstb = 1'b1; #1;
      a_wd = 9'h0FF; #1;
      for (int i = 0; i < 3; i++) begin
         a_wstb = 1'b0; #1; a_wstb = 1'b1; #1;
      end
      a_ra = 8'd8; #1;
      a_rsel = 1'b0; a_rstb = 1'b0; #1;
      chk("R9 free read R2 blocked", a_rd, 9'h007);
      chk("R6 free read good flag", {8'd0, a_rpe}, 9'h000);
      a_ra = 8'd7; #1;
      chk("R9 free read follows addr", a_rd, 9'h107);
      chk("R6 free read bad flag", {8'd0, a_rpe}, 9'h001);
      a_rstb = 1'b1; #1;
      a_ra = 8'd8; #1;
      chk("R3 free read hold", a_rd, 9'h107);
      chk("R3 free flag idle", {8'd0, a_rpe}, 9'h000);
      a_rsel = 1'b1; #1;
   endtask

   task automatic t_reset_keep();
      p_odd = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 reset clears clocked data", s_rd, 9'h000);
      chk("R10 reset clears free data", a_rd, 9'h000);
      rst_n = 1'b1;
      s_read("R10 contents kept", 8'd3, 9'h103);
   endtask

   initial begin : watchdog
      #(CLK_P * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      #(CLK_P * 2 + 1);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_basic();
      t_gating();
      t_hold();
      t_bad();
      t_polarity();
      t_collide();
      t_free();
      t_reset_keep();
      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule